// File: doc/BRIEF.md
# Bit-Fragment Packing Queue Bank

This block sits between a bit-plane coding engine and a memory write port. The engine emits short bit fragments, from zero to thirty-seven bits long, on a separate input lane for each queue. Each bit plane owns three queues: one for the insignificant-pixel stream, one for the insignificant-set stream and one for the significant-pixel stream. Bit planes are numbered 0 to 21, which gives 66 queues by default. Each queue joins its fragments into a continuous bit string and cuts that string into 32-bit words. Those words are held in a small per-queue word store.

A scheduler runs on every cycle. It picks the queue that holds the most words and sends one word from it to the single output port. With the word it gives the queue's identifier and a running per-queue word number. Whatever assigns memory addresses can build them from those two values. When any queue gets close to full, the block raises a global stall toward the engine. A flush input closes out every partially filled word at the end of a pass.

Top module: `frag_pack_bank`

## Requirements
- R1: While reset is held and on the first cycle after it, `stall` and `out_valid` are low and every queue is empty.
- R2: Packing is MSB-first. A fragment of length L uses `frag_data[L-1:0]`, and bit L-1 is sent first. The earliest unsent bit of a queue lands in bit 31 of that queue's next word.
- R3: Bits of `frag_data` at positions L and above have no effect on any output word.
- R4: A fragment of length 0 is accepted and changes no state. A later flush therefore emits exactly the bits that were present before it.
- R5: Lengths run from 0 to 37. A fragment may complete one word, or two words in the same cycle when the queue already held a partial word. A queue's words leave the block in the order their bits arrived.
- R6: An accepted `flush` turns every queue's partial word into a full word, with its bits left-aligned and zero-padded below. Queues with no partial bits emit nothing. All fragment inputs are ignored in a flush cycle.
- R7: Each cycle, if any queue holds a word, exactly one word is removed from the queue holding the most words. Ties go to the lowest identifier. A word can appear on the output at the earliest in the cycle after the clock edge that stored it.
- R8: `out_id` equals plane*3 + kind. Kind 0 is the insignificant-pixel queue, kind 1 the insignificant-set queue and kind 2 the significant-pixel queue.
- R9: `out_index` is the number of words already emitted by that queue since reset, modulo 2^IDX_W. It starts at 0.
- R10: `stall` is high whenever any queue holds DEPTH-1 or more words. In any cycle where `stall` is high, fragments and `flush` are ignored.
- R11: `out_valid` is low in the cycle after one in which every queue was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frag_data | input | NQ x FRAG_W | Per-queue fragment bits, right-aligned |
| frag_len | input | NQ x LEN_W | Per-queue fragment length, 0..37 |
| flush | input | 1 | Pad and emit all partial words |
| stall | output | 1 | Producer must hold; inputs ignored |
| out_valid | output | 1 | A word is on the output this cycle |
| out_word | output | WORD_W | Emitted 32-bit word |
| out_id | output | QID_W | Queue identifier of the word |
| out_index | output | IDX_W | Per-queue word number |

## Verification
Fragments and flushes are taken at a rising edge. Any word they complete is stored at that same edge, so `stall` changes right after it. The earliest the word can show up on `out_valid`/`out_word` is after the next rising edge, because the choice of queue uses the counts registered before the stores. The bench drives inputs at the falling edge and steps a behavioural model of this one-edge delay for the scheduler. At the following falling edge it compares every output with the model, so each result is sampled exactly one edge after the stimulus that caused it.

// File: rtl/frag_pack_pkg.sv
`timescale 1ns / 1ps
// Shared definitions for the fragment packing queue bank.
// Assumes queue identifier = plane * QUEUE_KINDS + kind.
package frag_pack_pkg;

    localparam int unsigned QUEUE_KINDS = 3;

    typedef enum logic [1:0] {
        KIND_PIX_INSIG = 2'd0,
        KIND_SET_INSIG = 2'd1,
        KIND_PIX_SIG   = 2'd2
    } queue_kind_e;

endpackage

// File: rtl/fpb_packer.sv
`timescale 1ns / 1ps
// Per-queue bit packer: joins MSB-first fragments with the held partial
// word and produces zero, one or two finished words per cycle.
// Assumes: len <= FRAG_W; take and flush_go are never high together;
// the caller has room for two words whenever it asserts take or flush_go.
module fpb_packer #(
    parameter int FRAG_W = 37,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              flush_go,
    input  logic [FRAG_W-1:0] frag,
    input  logic [LEN_W-1:0]  len,
    output logic [1:0]        push_n,
    output logic [WORD_W-1:0] w0,
    output logic [WORD_W-1:0] w1
);
    localparam int PEND_W = WORD_W - 1;
    localparam int COMB_W = PEND_W + FRAG_W;
    localparam int PC_W   = $clog2(WORD_W);
    localparam int N_W    = $clog2(COMB_W + 1);

    logic [PEND_W-1:0] pend_q, pend_d;
    logic [PC_W-1:0]   pcnt_q, pcnt_d;
    logic [FRAG_W-1:0] keep;
    logic [COMB_W-1:0] joined;
    logic [N_W-1:0]    total, rest;

    // Join held bits with the new fragment and cut finished words off the top.
    always_comb begin
        keep   = ~({FRAG_W{1'b1}} << len);
        joined = (COMB_W'(pend_q) << len) | COMB_W'(frag & keep);
        total  = N_W'(pcnt_q) + N_W'(len);
        push_n = 2'd0;
        w0     = '0;
        w1     = '0;
        rest   = N_W'(pcnt_q);
        pend_d = pend_q;
        pcnt_d = pcnt_q;
        if (flush_go) begin
            if (pcnt_q != '0) begin
                push_n = 2'd1;
                w0     = WORD_W'(pend_q) << (WORD_W - int'(pcnt_q));
            end
            pend_d = '0;
            pcnt_d = '0;
        end else if (take) begin
            if (total >= N_W'(2 * WORD_W)) begin
                push_n = 2'd2;
                w0     = WORD_W'(joined >> (total - N_W'(WORD_W)));
                w1     = WORD_W'(joined >> (total - N_W'(2 * WORD_W)));
                rest   = total - N_W'(2 * WORD_W);
            end else if (total >= N_W'(WORD_W)) begin
                push_n = 2'd1;
                w0     = WORD_W'(joined >> (total - N_W'(WORD_W)));
                rest   = total - N_W'(WORD_W);
            end else begin
                rest   = total;
            end
            pend_d = PEND_W'(joined & ~({COMB_W{1'b1}} << rest));
            pcnt_d = PC_W'(rest);
        end
    end

    // Hold the partial word between cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            pcnt_q <= '0;
        end else begin
            pend_q <= pend_d;
            pcnt_q <= pcnt_d;
        end
    end

    // R5: fragment lengths stay within the legal range
    p_len_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (int'(len) <= FRAG_W));

    // R5: two words in one cycle need bits already held
    p_two_need_partial_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n == 2'd2) |-> (pcnt_q != '0));

    // R6: an accepted flush leaves no partial bits behind
    p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_go |=> (pcnt_q == '0));

endmodule

// File: rtl/fpb_lane_fifo.sv
`timescale 1ns / 1ps
// Per-queue word store: circular buffer taking up to two words and
// giving up at most one word per cycle.
// Assumes the writer never pushes more than the free space allows.
module fpb_lane_fifo #(
    parameter int DEPTH  = 4,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        push_n,
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic              pop,
    output logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    // Store incoming words at the write position.
    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem_q[wr_q] <= w0;
        if (push_n == 2'd2) mem_q[bump(wr_q, 1)] <= w1;
    end

    // Advance pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= bump(wr_q, int'(push_n));
            rd_q  <= bump(rd_q, int'(pop));
            cnt_q <= cnt_q + CNT_W'(push_n) - CNT_W'(pop);
        end
    end

    assign count = cnt_q;
    assign head  = mem_q[rd_q];

    // R10: the stall threshold keeps every store within its capacity
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != 2'd0) |-> (int'(cnt_q) + int'(push_n) <= DEPTH));

    // R7: words are only drained from a queue that holds one
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));

endmodule

// File: rtl/fpb_picker.sv
`timescale 1ns / 1ps
// Drain scheduler: finds the queue with the largest word count,
// lowest identifier on ties. Purely combinational.
module fpb_picker #(
    parameter int NQ    = 66,
    parameter int CNT_W = 3,
    parameter int QID_W = 7
) (
    input  logic [NQ-1:0][CNT_W-1:0] counts,
    output logic [QID_W-1:0]         sel,
    output logic                     any
);
    // Linear scan; a strict compare keeps the earliest of equal counts.
    always_comb begin
        int best;
        best = 0;
        for (int i = 1; i < NQ; i++) begin
            if (counts[i] > counts[best]) best = i;
        end
        sel = QID_W'(best);
        any = (counts[best] != '0);
    end

endmodule

// File: rtl/frag_pack_bank.sv
`timescale 1ns / 1ps
// Fragment packing queue bank: one packer and word store per queue
// (three queues per bit plane), a fullest-first drain scheduler and a
// registered single-word output. Stall is raised from registered counts.
// Assumes DEPTH >= 3 so that two words always fit when stall is low.
module frag_pack_bank #(
    parameter int PLANES = 22,
    parameter int FRAG_W = 37,
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4,
    parameter int IDX_W  = 16,
    localparam int NQ    = PLANES * frag_pack_pkg::QUEUE_KINDS,
    localparam int LEN_W = $clog2(FRAG_W + 1),
    localparam int QID_W = $clog2(NQ)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NQ-1:0][FRAG_W-1:0]    frag_data,
    input  logic [NQ-1:0][LEN_W-1:0]     frag_len,
    input  logic                         flush,
    output logic                         stall,
    output logic                         out_valid,
    output logic [WORD_W-1:0]            out_word,
    output logic [QID_W-1:0]             out_id,
    output logic [IDX_W-1:0]             out_index
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [NQ-1:0][CNT_W-1:0] lane_cnt;
    logic [WORD_W-1:0]        lane_head [NQ];
    logic [IDX_W-1:0]         lane_idx  [NQ];
    logic [NQ-1:0]            lane_pop, near_full, nonempty;
    logic [QID_W-1:0]         pick_sel;
    logic                     pick_any, accept;
    logic [WORD_W-1:0]        head_sel;
    logic [IDX_W-1:0]         idx_sel;

    assign stall  = |near_full;
    assign accept = ~stall;

    for (genvar i = 0; i < NQ; i++) begin : g_lane
        logic [1:0]        push_n;
        logic [WORD_W-1:0] w0, w1;

        fpb_packer #(.FRAG_W(FRAG_W), .WORD_W(WORD_W), .LEN_W(LEN_W)) u_pack (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (accept && !flush && (frag_len[i] != '0)),
            .flush_go (accept && flush),
            .frag     (frag_data[i]),
            .len      (frag_len[i]),
            .push_n   (push_n),
            .w0       (w0),
            .w1       (w1)
        );

        fpb_lane_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .push_n (push_n),
            .w0     (w0),
            .w1     (w1),
            .pop    (lane_pop[i]),
            .count  (lane_cnt[i]),
            .head   (lane_head[i])
        );

        assign lane_pop[i]  = pick_any && (pick_sel == QID_W'(i));
        assign near_full[i] = (lane_cnt[i] >= CNT_W'(DEPTH - 1));
        assign nonempty[i]  = (lane_cnt[i] != '0);

        // Per-queue emitted word number for address generation.
        always_ff @(posedge clk) begin
            if (!rst_n) lane_idx[i] <= '0;
            else if (lane_pop[i]) lane_idx[i] <= lane_idx[i] + 1'b1;
        end
    end

    fpb_picker #(.NQ(NQ), .CNT_W(CNT_W), .QID_W(QID_W)) u_pick (
        .counts (lane_cnt),
        .sel    (pick_sel),
        .any    (pick_any)
    );

    // Route the chosen queue's head word and word number.
    always_comb begin
        head_sel = '0;
        idx_sel  = '0;
        for (int i = 0; i < NQ; i++) begin
            if (pick_sel == QID_W'(i)) begin
                head_sel = lane_head[i];
                idx_sel  = lane_idx[i];
            end
        end
    end

    // Register the drained word onto the output port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_id    <= '0;
            out_index <= '0;
        end else begin
            out_valid <= pick_any;
            out_word  <= head_sel;
            out_id    <= pick_sel;
            out_index <= idx_sel;
        end
    end

    // R8: every emitted identifier names an existing queue
    p_out_id_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_id) < NQ));

    // R11: nothing is emitted after a cycle with all queues empty
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (nonempty == '0) |=> !out_valid);

endmodule

// File: tb/frag_pack_bank_test.sv
`timescale 1ns / 1ps
// Self-checking bench: behavioural reference model compared on every clock.
module frag_pack_bank_test;
    localparam int PLANES = 22;
    localparam int NQ     = PLANES * 3;
    localparam int FW     = 37;
    localparam int DEPTH  = 4;
    localparam int LW     = 6;
    localparam int QW     = 7;
    localparam int IW     = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                  rst_n;
    logic [NQ-1:0][FW-1:0] fd;
    logic [NQ-1:0][LW-1:0] fl;
    logic                  ff;
    logic                  stall, out_valid;
    logic [31:0]           out_word;
    logic [QW-1:0]         out_id;
    logic [IW-1:0]         out_index;

    frag_pack_bank #(.PLANES(PLANES), .FRAG_W(FW), .WORD_W(32), .DEPTH(DEPTH), .IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .frag_data(fd), .frag_len(fl), .flush(ff),
        .stall(stall), .out_valid(out_valid), .out_word(out_word),
        .out_id(out_id), .out_index(out_index)
    );

    // reference model state
    logic [31:0]  mw [NQ][16];
    int           mrd [NQ];
    int           mwr [NQ];
    logic [127:0] mpend [NQ];
    int           mpc [NQ];
    int           memit [NQ];
    logic         e_valid, e_stall;
    logic [31:0]  e_word;
    int           e_id, e_idx;
    int           n_vec = 0, n_bad = 0;
    bit           done = 0;

    function automatic int mcount(input int q);
        return mwr[q] - mrd[q];
    endfunction

    task automatic mpush(input int q, input logic [31:0] w);
        mw[q][mwr[q] % 16] = w;
        mwr[q]++;
    endtask

    task automatic model_reset();
        for (int q = 0; q < NQ; q++) begin
            mrd[q] = 0; mwr[q] = 0; mpend[q] = '0; mpc[q] = 0; memit[q] = 0;
        end
        e_valid = 0; e_stall = 0; e_word = '0; e_id = 0; e_idx = 0;
    endtask

    // One clock of the model: drain from pre-edge counts, then accept inputs.
    task automatic model_step();
        bit pre_stall;
        int best;
        pre_stall = 0;
        best = 0;
        for (int q = 0; q < NQ; q++) begin
            if (mcount(q) >= DEPTH - 1) pre_stall = 1;
            if (mcount(q) > mcount(best)) best = q;
        end
        if (mcount(best) > 0) begin
            e_valid = 1;
            e_word  = mw[best][mrd[best] % 16];
            e_id    = best;
            e_idx   = memit[best];
            memit[best] = (memit[best] + 1) % (1 << IW);
            mrd[best]++;
        end else begin
            e_valid = 0;
        end
        if (!pre_stall) begin
            for (int q = 0; q < NQ; q++) begin
                if (ff) begin
                    if (mpc[q] > 0) mpush(q, 32'(mpend[q] << (32 - mpc[q])));
                    mpend[q] = '0;
                    mpc[q] = 0;
                end else if (fl[q] != 0) begin
                    logic [127:0] j;
                    int n, len;
                    len = int'(fl[q]);
                    j = (mpend[q] << len) | (128'(fd[q]) & ((128'h1 << len) - 128'h1));
                    n = mpc[q] + len;
                    while (n >= 32) begin
                        mpush(q, 32'(j >> (n - 32)));
                        n = n - 32;
                    end
                    mpend[q] = j & ((128'h1 << n) - 128'h1);
                    mpc[q] = n;
                end
            end
        end
        e_stall = 0;
        for (int q = 0; q < NQ; q++) if (mcount(q) >= DEPTH - 1) e_stall = 1;
    endtask

    task automatic compare(input string ph);
        n_vec++;
        if (out_valid !== e_valid) begin
            n_bad++;
            $display("FAIL R7 [%s] out_valid=%0b expected %0b", ph, out_valid, e_valid);
        end else if (e_valid) begin
            if (out_id !== QW'(e_id)) begin
                n_bad++;
                $display("FAIL R7/R8 [%s] out_id=%0d expected %0d", ph, out_id, e_id);
            end
            if (out_word !== e_word) begin
                n_bad++;
                $display("FAIL R2 [%s] out_word=%h expected %h", ph, out_word, e_word);
            end
            if (out_index !== IW'(e_idx)) begin
                n_bad++;
                $display("FAIL R9 [%s] out_index=%0d expected %0d", ph, out_index, e_idx);
            end
        end
        if (stall !== e_stall) begin
            n_bad++;
            $display("FAIL R10 [%s] stall=%0b expected %0b", ph, stall, e_stall);
        end
    endtask

    task automatic tick(input string ph);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(ph);
    endtask

    task automatic idle_inputs();
        fd = '0; fl = '0; ff = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R7 watchdog expired, actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        rst_n = 1'b0;
        idle_inputs();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state on the ports
        n_vec++;
        if (stall !== 1'b0 || out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 stall=%0b out_valid=%0b expected 0 0", stall, out_valid);
        end
        rst_n = 1'b1;
        tick("R1");

        // R2: full word in one fragment, then four byte fragments
        fd[0] = 37'h00A5A51234; fl[0] = 6'd32;
        tick("R2");
        idle_inputs();
        fl[5] = 6'd8; fd[5] = 37'hC3; tick("R2");
        fd[5] = 37'h5A; tick("R2");
        fd[5] = 37'h0F; tick("R2");
        fd[5] = 37'hF0; tick("R2");
        idle_inputs();
        repeat (3) tick("R2");

        // R3: junk above the length must not leak into words
        for (int k = 0; k < 8; k++) begin
            fd[2] = {25'h1FFFFFF, 12'(k * 37 + 5)}; fl[2] = 6'd12;
            tick("R3");
        end
        idle_inputs();
        repeat (3) tick("R3");

        // R4: zero-length fragments with busy data change nothing
        fd[9] = 37'h15; fl[9] = 6'd5; tick("R4");
        idle_inputs();
        for (int k = 0; k < 5; k++) begin
            for (int q = 0; q < NQ; q++) fd[q] = '1;
            tick("R4");
        end
        idle_inputs();
        ff = 1'b1; tick("R4");
        idle_inputs();
        repeat (3) tick("R4");

        // R5: longest fragments spanning word boundaries
        for (int k = 0; k < 12; k++) begin
            r = {$urandom(), $urandom()};
            fd[7] = r[36:0]; fl[7] = 6'd37;
            tick("R5");
        end
        idle_inputs();
        repeat (6) tick("R5");

        // R6: flush pads partial words; fragments in that cycle ignored
        fd[11] = 37'h3; fl[11] = 6'd2; fd[12] = 37'h1ABCDEF; fl[12] = 6'd25;
        tick("R6");
        idle_inputs();
        ff = 1'b1; fd[13] = 37'h1FFFFFFFFF; fl[13] = 6'd37;
        tick("R6");
        idle_inputs();
        ff = 1'b1; tick("R6");
        idle_inputs();
        repeat (4) tick("R6");

        // R7: tie goes to the lowest identifier; fuller queue first
        fd[3] = 37'h11111111; fl[3] = 6'd32;
        fd[1] = 37'h22222222; fl[1] = 6'd32;
        fd[20] = 37'h1F00000000; fl[20] = 6'd37;
        tick("R7");
        idle_inputs();
        fd[20] = 37'h0123456789; fl[20] = 6'd37; fd[40] = 37'h7; fl[40] = 6'd32;
        tick("R7");
        idle_inputs();
        repeat (8) tick("R7");

        // R10: heavy load raises stall; inputs during stall are ignored
        for (int k = 0; k < 30; k++) begin
            for (int q = 30; q < 36; q++) begin
                r = {$urandom(), $urandom()};
                fd[q] = r[36:0]; fl[q] = 6'd37;
            end
            ff = (k % 9 == 8);
            tick("R10");
        end
        idle_inputs();
        repeat (40) tick("R10");

        // R8/R9: random traffic across all queues
        for (int k = 0; k < 3000; k++) begin
            idle_inputs();
            for (int q = 0; q < NQ; q++) begin
                if ($urandom_range(0, 31) == 0) begin
                    r = {$urandom(), $urandom()};
                    fd[q] = r[36:0];
                    fl[q] = 6'($urandom_range(0, 37));
                end
            end
            ff = ($urandom_range(0, 63) == 0);
            tick("R8");
        end
        idle_inputs();
        ff = 1'b1; tick("R9");
        idle_inputs();

        // R11: drain to empty and stay quiet
        repeat (300) tick("R11");

        done = 1;
        summary();
        $finish;
    end

endmodule